// File: doc/BRIEF.md
# Dual Variable-Page-Size Translation Lookaside Buffer

This block translates virtual addresses to physical addresses with two translation caches that are searched side by side. Each cache holds a parameterised number of fully associative entries (16 by default). Each cache has its own page size, chosen from eight sizes that run from 1 KB to 16 MB in steps of four. Because of this, one cache can map large regions such as a whole ROM or frame buffer while the other maps small pages.

Each entry holds a virtual page tag, a physical page number, a valid bit and four page attributes:
- write-through, which replaces the default copy-back data-cache policy;
- noncacheable, which sends every access to the external bus;
- parity checking enabled;
- a 16-bit external bus instead of 32-bit.

Software loads entries through a direct write port that names the cache and the slot. There is no replacement policy and no table walk. A single global invalidate clears every entry in both caches. A lookup returns a registered result one cycle later: the hit or miss status, the physical address, the attributes and which cache supplied the hit.

Top module: `dual_tlb`

## Requirements
- R1: After reset, the response outputs are all low, every entry in both caches is invalid (so a lookup misses), and both page-size codes are 0.
- R2: A write with `ent_we` high stores the tag, physical page and attributes in the slot `ent_slot` of the cache chosen by `ent_bank` (0 or 1). It marks that slot valid, and the entry is visible to a lookup presented in the next cycle.
- R3: The 3-bit page-size code c of a cache gives an offset width of 10+2c bits. Code 0 is 1 KB and code 7 is 16 MB. A code written with `psz_we` applies to lookups from the next cycle on, and writing one cache's code leaves the other cache's code unchanged.
- R4: The tag comparison ignores the virtual-address bits below the offset width of that cache. This includes the low bits of the stored tag.
- R5: On a hit, `rsp_pa` equals the entry's physical page placed at bit 10 and above, with every bit below the offset width taken from the looked-up virtual address.
- R6: On a hit, the attribute outputs `rsp_wthru`, `rsp_nocache`, `rsp_parchk` and `rsp_bus16` equal the values stored in the hitting entry.
- R7: The response is registered. `rsp_valid` is high exactly in the cycle after `lk_req` was high, and it stays low otherwise.
- R8: A miss raises `rsp_miss`, keeps `rsp_hit` low, and drives `rsp_pa`, `rsp_bank` and all attributes to zero. `rsp_hit` and `rsp_miss` are never high together, and they are both low when `rsp_valid` is low.
- R9: When both caches hit, the result comes from cache 0, and `rsp_bank` is 0. It is 1 when only cache 1 hits.
- R10: `inv_all` clears every valid bit in both caches in one cycle. It takes priority over an entry write in the same cycle.
- R11: When several entries in one cache match, the one with the lowest slot number wins. Rewriting a slot replaces its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_we | input | 1 | Entry write strobe |
| ent_bank | input | 1 | Cache selected for the write |
| ent_slot | input | $clog2(ENTRIES) | Slot written |
| ent_vpn | input | ADDR_W-10 | Virtual page tag (address bits above bit 9) |
| ent_ppn | input | ADDR_W-10 | Physical page number (address bits above bit 9) |
| ent_wthru | input | 1 | Attribute: write-through |
| ent_nocache | input | 1 | Attribute: noncacheable |
| ent_parchk | input | 1 | Attribute: parity checking enabled |
| ent_bus16 | input | 1 | Attribute: 16-bit bus (0 means 32-bit) |
| psz_we | input | 1 | Page-size code write strobe |
| psz_bank | input | 1 | Cache whose code is written |
| psz_code | input | 3 | New page-size code |
| inv_all | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_va | input | ADDR_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_bank | output | 1 | Cache that supplied the hit |
| rsp_pa | output | ADDR_W | Physical address |
| rsp_wthru | output | 1 | Write-through attribute |
| rsp_nocache | output | 1 | Noncacheable attribute |
| rsp_parchk | output | 1 | Parity-check attribute |
| rsp_bus16 | output | 1 | 16-bit bus attribute |

## Verification
The bench applies every stimulus on the falling clock edge and samples results 1 ns after the following rising edge.

- Lookup results are due one rising edge after `lk_req`, so each lookup task samples exactly there.
- Entry writes, page-size writes and `inv_all` act on their own rising edge. The next lookup is therefore presented at the falling edge after that, and its result is read one rising edge later again.
- The idle check samples a cycle with `lk_req` low, to confirm that `rsp_valid` falls back.

// File: rtl/tlb_pkg.sv
// Package: shared constants and the per-page attribute record for the dual TLB.
// Assumes the smallest page is 1 KB, so address bits [9:0] are never translated.
package tlb_pkg;
    localparam int MIN_OFF = 10;
    localparam int PSZ_W   = 3;

    typedef struct packed {
        logic wthru;
        logic nocache;
        logic parchk;
        logic bus16;
    } page_attr_t;
endpackage

// File: rtl/tlb_psz_reg.sv
// tlb_psz_reg: holds the page-size code of one cache.
// Assumes the code is loaded by a one-cycle write strobe; the reset value is 0 (1 KB).
module tlb_psz_reg
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PSZ_W-1:0] code_in,
    output logic [PSZ_W-1:0] code_q
);
    // Load the code on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  code_q <= '0;
        else if (we) code_q <= code_in;
    end

    // R3
    psz_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (code_q == $past(code_in)));

    // R3
    psz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(code_q));
endmodule

// File: rtl/tlb_array.sv
// tlb_array: one fully associative translation cache with a direct-write port.
// Assumes the page-size code is stable during a lookup. Several matches resolve to
// the lowest slot, and the match logic is purely combinational.
module tlb_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    input  page_attr_t       wr_attr,
    input  logic [PSZ_W-1:0] psz_code,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [VPN_W-1:0] hit_ppn,
    output page_attr_t       hit_attr
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [VPN_W-1:0]   ppn_q  [ENTRIES];
    page_attr_t         attr_q [ENTRIES];
    logic [VPN_W-1:0]   ign_mask;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   win;

    // Valid bits: reset and invalidate clear them all, and a write sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) valid_q <= '0;
        else if (we)           valid_q[wr_slot] <= 1'b1;
    end

    // Entry payload storage, which needs no reset because valid guards it.
    always_ff @(posedge clk) begin
        if (we) begin
            vpn_q[wr_slot]  <= wr_vpn;
            ppn_q[wr_slot]  <= wr_ppn;
            attr_q[wr_slot] <= wr_attr;
        end
    end

    // Tag bits that lie inside the page offset for the current size.
    always_comb begin
        for (int b = 0; b < VPN_W; b++) ign_mask[b] = (b < 2 * int'(psz_code));
    end

    // Per-entry comparison, ignoring the offset bits.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid_q[e] && (((vpn_q[e] ^ lk_vpn) & ~ign_mask) == '0);
    end

    // Priority pick: the lowest matching slot wins.
    always_comb begin
        win = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) if (match[i]) win = IDX_W'(i);
    end

    assign hit      = |match;
    assign hit_ppn  = ppn_q[win];
    assign hit_attr = attr_q[win];

    // R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    // R2
    wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !inv_all) |=> valid_q[$past(wr_slot)]);
endmodule

// File: rtl/tlb_resp.sv
// tlb_resp: merges the two cache results, builds the physical address and
// registers the response. Assumes cache 0 has priority, and that the
// address is ADDR_W bits on both the virtual and the physical side.
module tlb_resp
    import tlb_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int VPN_W = ADDR_W - MIN_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic              hit0,
    input  logic [VPN_W-1:0]  ppn0,
    input  page_attr_t        attr0,
    input  logic [PSZ_W-1:0]  psz0,
    input  logic              hit1,
    input  logic [VPN_W-1:0]  ppn1,
    input  page_attr_t        attr1,
    input  logic [PSZ_W-1:0]  psz1,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_bank,
    output logic [ADDR_W-1:0] rsp_pa,
    output page_attr_t        rsp_attr
);
    logic              sel1;
    logic [VPN_W-1:0]  ppn_s;
    logic [PSZ_W-1:0]  psz_s;
    page_attr_t        attr_s;
    logic [ADDR_W-1:0] off_mask;
    logic [ADDR_W-1:0] pa_c;
    logic              any_hit;

    // Source choice: cache 1 is used only when cache 0 misses.
    always_comb begin
        any_hit = hit0 || hit1;
        sel1    = !hit0 && hit1;
        ppn_s   = sel1 ? ppn1  : ppn0;
        attr_s  = sel1 ? attr1 : attr0;
        psz_s   = sel1 ? psz1  : psz0;
    end

    // Offset mask for the chosen cache's page size, and the address merge.
    always_comb begin
        for (int b = 0; b < ADDR_W; b++) off_mask[b] = (b < MIN_OFF + 2 * int'(psz_s));
        pa_c = ({ppn_s, {MIN_OFF{1'b0}}} & ~off_mask) | (lk_va & off_mask);
    end

    // Response register: zero payload on a miss or when there is no request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_bank  <= 1'b0;
            rsp_pa    <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && any_hit;
            rsp_miss  <= lk_req && !any_hit;
            rsp_bank  <= lk_req && sel1;
            rsp_pa    <= (lk_req && any_hit) ? pa_c : '0;
            rsp_attr  <= (lk_req && any_hit) ? attr_s : '0;
        end
    end

    // R7
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R7
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R8
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_miss}) == (rsp_valid ? 1 : 0));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pa == '0 && rsp_attr == '0 && !rsp_bank));

    // R9
    bank0_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && hit0) |=> (rsp_hit && !rsp_bank));

    // R5
    low_offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (hit0 || hit1)) |=> (rsp_pa[MIN_OFF-1:0] == $past(lk_va[MIN_OFF-1:0])));
endmodule

// File: rtl/dual_tlb.sv
// dual_tlb: two translation caches, each with its own page-size code, searched
// in parallel, with a one-cycle registered response. Assumes software keeps the
// tags unique within a cache; if they are not, the lowest slot wins.
module dual_tlb
    import tlb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    localparam int VPN_W  = ADDR_W - MIN_OFF,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_we,
    input  logic              ent_bank,
    input  logic [IDX_W-1:0]  ent_slot,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [VPN_W-1:0]  ent_ppn,
    input  logic              ent_wthru,
    input  logic              ent_nocache,
    input  logic              ent_parchk,
    input  logic              ent_bus16,
    input  logic              psz_we,
    input  logic              psz_bank,
    input  logic [PSZ_W-1:0]  psz_code,
    input  logic              inv_all,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_bank,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_wthru,
    output logic              rsp_nocache,
    output logic              rsp_parchk,
    output logic              rsp_bus16
);
    localparam int NBANK = 2;

    page_attr_t       wr_attr;
    page_attr_t       out_attr;
    logic             hit_w  [NBANK];
    logic [VPN_W-1:0] ppn_w  [NBANK];
    page_attr_t       attr_w [NBANK];
    logic [PSZ_W-1:0] psz_w  [NBANK];

    assign wr_attr = '{wthru: ent_wthru, nocache: ent_nocache,
                       parchk: ent_parchk, bus16: ent_bus16};

    // One page-size register and one cache per bank.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        tlb_psz_reg u_psz (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (psz_we && (psz_bank == 1'(g))),
            .code_in (psz_code),
            .code_q  (psz_w[g])
        );

        tlb_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_arr (
            .clk      (clk),
            .rst_n    (rst_n),
            .inv_all  (inv_all),
            .we       (ent_we && (ent_bank == 1'(g))),
            .wr_slot  (ent_slot),
            .wr_vpn   (ent_vpn),
            .wr_ppn   (ent_ppn),
            .wr_attr  (wr_attr),
            .psz_code (psz_w[g]),
            .lk_vpn   (lk_va[ADDR_W-1:MIN_OFF]),
            .hit      (hit_w[g]),
            .hit_ppn  (ppn_w[g]),
            .hit_attr (attr_w[g])
        );
    end

    tlb_resp #(.ADDR_W(ADDR_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_va     (lk_va),
        .hit0      (hit_w[0]),
        .ppn0      (ppn_w[0]),
        .attr0     (attr_w[0]),
        .psz0      (psz_w[0]),
        .hit1      (hit_w[1]),
        .ppn1      (ppn_w[1]),
        .attr1     (attr_w[1]),
        .psz1      (psz_w[1]),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_bank  (rsp_bank),
        .rsp_pa    (rsp_pa),
        .rsp_attr  (out_attr)
    );

    assign rsp_wthru   = out_attr.wthru;
    assign rsp_nocache = out_attr.nocache;
    assign rsp_parchk  = out_attr.parchk;
    assign rsp_bus16   = out_attr.bus16;

    // R3
    psz_other_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psz_we && psz_bank) |=> $stable(psz_w[0]));
endmodule

// File: tb/dual_tlb_bench.sv
// Directed bench for dual_tlb: one task per scenario, each checking its own results.
module dual_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_we = 1'b0, ent_bank = 1'b0;
    logic [3:0]  ent_slot = '0;
    logic [21:0] ent_vpn = '0, ent_ppn = '0;
    logic        ent_wthru = 1'b0, ent_nocache = 1'b0, ent_parchk = 1'b0, ent_bus16 = 1'b0;
    logic        psz_we = 1'b0, psz_bank = 1'b0;
    logic [2:0]  psz_code = '0;
    logic        inv_all = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_bank;
    logic [31:0] rsp_pa;
    logic        rsp_wthru, rsp_nocache, rsp_parchk, rsp_bus16;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int code0  = 0;
    int code1  = 0;

    always #4 clk = ~clk;

    dual_tlb u_dual_tlb (
        .clk(clk), .rst_n(rst_n),
        .ent_we(ent_we), .ent_bank(ent_bank), .ent_slot(ent_slot),
        .ent_vpn(ent_vpn), .ent_ppn(ent_ppn),
        .ent_wthru(ent_wthru), .ent_nocache(ent_nocache),
        .ent_parchk(ent_parchk), .ent_bus16(ent_bus16),
        .psz_we(psz_we), .psz_bank(psz_bank), .psz_code(psz_code),
        .inv_all(inv_all), .lk_req(lk_req), .lk_va(lk_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_bank(rsp_bank), .rsp_pa(rsp_pa),
        .rsp_wthru(rsp_wthru), .rsp_nocache(rsp_nocache),
        .rsp_parchk(rsp_parchk), .rsp_bus16(rsp_bus16)
    );

    function automatic logic [31:0] exp_pa(logic [21:0] ppn, logic [31:0] va, int code);
        logic [31:0] m;
        m = (32'h1 << (10 + 2 * code)) - 32'h1;
        return ({ppn, 10'b0} & ~m) | (va & m);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_ent(logic bank, int slot, logic [31:0] va, logic [21:0] ppn, logic [3:0] at);
        @(negedge clk);
        ent_we = 1'b1; ent_bank = bank; ent_slot = 4'(slot);
        ent_vpn = va[31:10]; ent_ppn = ppn;
        {ent_wthru, ent_nocache, ent_parchk, ent_bus16} = at;
        @(posedge clk); #1;
        ent_we = 1'b0;
    endtask

    task automatic set_psz(logic bank, int code);
        @(negedge clk);
        psz_we = 1'b1; psz_bank = bank; psz_code = 3'(code);
        @(posedge clk); #1;
        psz_we = 1'b0;
        if (bank) code1 = code; else code0 = code;
    endtask

    task automatic lookup(logic [31:0] va);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va;
        @(posedge clk); #1;
        lk_req = 1'b0;
    endtask

    // Expect a hit from the given bank with the given page and attributes {wt,nc,par,b16}.
    task automatic expect_hit(string req, logic [31:0] va, logic bank, logic [21:0] ppn, logic [3:0] at);
        lookup(va);
        check(req, "valid/hit/miss", {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'b110);
        check(req, "bank", {31'b0, rsp_bank}, {31'b0, bank});
        check(req, "pa", rsp_pa, exp_pa(ppn, va, bank ? code1 : code0));
        check(req, "attr", {28'b0, rsp_wthru, rsp_nocache, rsp_parchk, rsp_bus16}, {28'b0, at});
    endtask

    task automatic expect_miss(string req, logic [31:0] va);
        lookup(va);
        check(req, "valid/hit/miss", {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'b101);
        check(req, "pa on miss", rsp_pa, 32'h0);
        check(req, "attr/bank on miss",
              {27'b0, rsp_bank, rsp_wthru, rsp_nocache, rsp_parchk, rsp_bus16}, 32'h0);
    endtask

    task automatic t_reset;
        check("R1", "outputs in reset", {28'b0, rsp_valid, rsp_hit, rsp_miss, rsp_bank}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        expect_miss("R1", 32'h1234_5678);
    endtask

    task automatic t_basic;
        write_ent(1'b0, 3, 32'h1234_5678, 22'h0F0F0, 4'b0000);
        expect_hit("R2", 32'h1234_5678, 1'b0, 22'h0F0F0, 4'b0000);
        expect_hit("R5", 32'h1234_57FF, 1'b0, 22'h0F0F0, 4'b0000);
        expect_miss("R8", 32'h1234_5C00);
    endtask

    task automatic t_attr;
        write_ent(1'b0, 7, 32'h0000_4000, 22'h00123, 4'b1011);
        write_ent(1'b0, 8, 32'h0000_8000, 22'h00456, 4'b0100);
        expect_hit("R6", 32'h0000_43FF, 1'b0, 22'h00123, 4'b1011);
        expect_hit("R6", 32'h0000_8001, 1'b0, 22'h00456, 4'b0100);
    endtask

    task automatic t_idle;
        @(negedge clk); @(posedge clk); #1;
        check("R7", "no request", {29'b0, rsp_valid, rsp_hit, rsp_miss}, 32'h0);
    endtask

    task automatic t_size;
        set_psz(1'b1, 7);
        write_ent(1'b1, 0, 32'hAB12_3456, 22'h3FFFFF, 4'b0001);
        expect_hit("R4", 32'hABFE_DCBA, 1'b1, 22'h3FFFFF, 4'b0001);
        check("R3", "16MB pa", rsp_pa, 32'hFFFE_DCBA);
        expect_miss("R4", 32'hAC00_0000);
        expect_miss("R3", 32'h1234_5A78);
        set_psz(1'b0, 2);
        write_ent(1'b0, 1, 32'h7654_0000, 22'h12345, 4'b0000);
        expect_hit("R3", 32'h7654_3FFF, 1'b0, 22'h12345, 4'b0000);
        check("R5", "16KB pa", rsp_pa, 32'h048D_3FFF);
        expect_miss("R3", 32'h7654_4000);
    endtask

    task automatic t_both;
        write_ent(1'b0, 0, 32'hAB00_0000, 22'h11111, 4'b1000);
        expect_hit("R9", 32'hAB00_0123, 1'b0, 22'h11111, 4'b1000);
    endtask

    task automatic t_prio;
        write_ent(1'b0, 9, 32'h5000_0000, 22'h00999, 4'b0000);
        write_ent(1'b0, 5, 32'h5000_0000, 22'h00555, 4'b0000);
        expect_hit("R11", 32'h5000_0010, 1'b0, 22'h00555, 4'b0000);
        write_ent(1'b0, 5, 32'h5000_0000, 22'h00777, 4'b0010);
        expect_hit("R11", 32'h5000_0010, 1'b0, 22'h00777, 4'b0010);
    endtask

    task automatic t_inval;
        @(negedge clk); inv_all = 1'b1;
        @(posedge clk); #1; inv_all = 1'b0;
        expect_miss("R10", 32'h5000_0010);
        expect_miss("R10", 32'hAB00_0123);
        @(negedge clk);
        inv_all = 1'b1; ent_we = 1'b1; ent_bank = 1'b0; ent_slot = 4'd2;
        ent_vpn = 22'h0C000; ent_ppn = 22'h00ABC;
        @(posedge clk); #1;
        inv_all = 1'b0; ent_we = 1'b0;
        expect_miss("R10", 32'h0300_0000);
        write_ent(1'b0, 2, 32'h0300_0000, 22'h00ABC, 4'b0000);
        expect_hit("R2", 32'h0300_0000, 1'b0, 22'h00ABC, 4'b0000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_attr();
        t_idle();
        t_size();
        t_both();
        t_prio();
        t_inval();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule